// File: doc/BRIEF.md
# SPI Register-Access Target

This block is the serial-peripheral-interface front end of a small byte-wide register file. An external controller selects the block with an active-low chip select, sends an opcode byte, then a register address byte, then any number of data bytes. On a write, each complete data byte becomes a one-cycle write strobe on a parallel register port. On a read, each data byte is fetched over the same port and shifted out on the serial output. A pointer loaded from the address byte steps after every data byte, so a burst walks through the register file.

The serial pins are not used as clocks. They are oversampled on the system clock through a synchronizer, and serial clock edges are found by comparing successive samples. The controller may idle the serial clock low or high (modes 0,0 and 1,1). Two strap inputs give the block a sub-address inside the opcode, so up to four targets can share one chip select. The register side uses the same address, write data, write strobe, read strobe and read data signals as an I2C front end would, so either front end can sit on the same register file.

Top module: `spi_regacc`

## Requirements
- R1: After reset `miso_oe`, `reg_we` and `reg_re` are low, and no strobe is issued while `cs_n` stays high.
- R2: The first byte after `cs_n` falls is the opcode, sent MSB first as bits 7..3 = 01000, bits 2..1 = sub-address, bit 0 = direction (0 write, 1 read). With `addr_cmp_en` high, bits 2..1 must equal `hw_addr` (bit 2 = `hw_addr[1]`).
- R3: With `addr_cmp_en` low, the opcode is accepted only when bits 2..1 are 00, whatever `hw_addr` holds.
- R4: An opcode with wrong fixed bits or a wrong sub-address makes the block ignore the rest of the transaction: no strobe, and `miso_oe` stays low.
- R5: In a write, every complete data byte after the address byte produces one `reg_we` pulse of one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte (MSB first).
- R6: In a read, each data byte is taken from `reg_rdata` in the cycle `reg_re` is high (read data is combinational on `reg_addr`) and is shifted out on `miso`, MSB first, changing after SCK falling edges; `miso_oe` is high during the data bytes of an accepted read.
- R7: With `seq_en` high the pointer steps by one after each data byte and goes from 0x0A to 0x00.
- R8: With `seq_en` low the pointer keeps the address-byte value for the whole transaction.
- R9: Input is taken on SCK rising edges in both idle-low (mode 0,0) and idle-high (mode 1,1) serial clocks.
- R10: When `cs_n` rises during a byte, that partial byte is dropped and no write strobe is issued for it.
- R11: `miso_oe` is low once `cs_n` has been high for five clock cycles.
- R12: `reg_we` and `reg_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the controller |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Drive enable for the external tri-state buffer on `miso` |
| hw_addr | input | 2 | Strapped sub-address |
| addr_cmp_en | input | 1 | Enables the sub-address compare |
| seq_en | input | 1 | Enables pointer stepping after each data byte |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | Write strobe, one cycle |
| reg_re | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 8 | Read data from the register file |

## Verification
Writes and reads are run in both serial clock modes, single bytes and bursts, so that a wrong bit order, a wrong edge choice or a missed mode shows up as corrupted bytes. Bursts that start at 0x09 cross the last register and tell a correct wrap apart from an overrun, and the same burst with stepping off tells a held pointer from a moving one. Opcodes with a wrong sub-address, wrong fixed bits, and a sub-address that is only valid while the compare is off separate the two compare settings, and each rejected transaction is followed by a read-back that shows the register file untouched. A chip select raised in the middle of a byte checks that only the finished bytes reach the register port.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int OPC_W  = 5;

  localparam logic [OPC_W-1:0] OPC_FIXED = 5'b01000;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPCODE,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[CHAIN_W-WIDTH-1:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              mosi_s,
  input  logic [1:0]        hw_addr,
  input  logic              addr_cmp_en,
  output phase_t            phase,
  output logic              rd_mode,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              addr_load,
  output logic [BYTE_W-1:0] addr_val,
  output logic              wr_pulse,
  output logic              step_pulse,
  output logic [BYTE_W-1:0] wr_byte
);

  phase_t              phase_q, phase_d, cur_ph;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-2:0]   rx_q, rx_d;
  logic                rd_q, rd_d;
  logic                wr_q, wr_d;
  logic                step_q, step_d;
  logic [BYTE_W-1:0]   wb_q, wb_d;
  logic [BYTE_W-1:0]   byte_now;
  logic [1:0]          want_sub;
  logic                opc_ok;
  logic                last_bit;

  assign byte_now = {rx_q, mosi_s};
  assign cur_ph   = (phase_q == PH_IDLE) ? PH_OPCODE : phase_q;
  assign last_bit = cs_act & sck_rise & (cnt_q == CNT_W'(BYTE_W - 1));
  assign want_sub = addr_cmp_en ? hw_addr : 2'b00;
  assign opc_ok   = (byte_now[BYTE_W-1 -: OPC_W] == OPC_FIXED) &&
                    (byte_now[2:1] == want_sub);

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    rx_d      = rx_q;
    rd_d      = rd_q;
    wr_d      = 1'b0;
    step_d    = 1'b0;
    wb_d      = wb_q;
    addr_load = 1'b0;
    if (!cs_act) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      phase_d = cur_ph;
      if (sck_rise) begin
        cnt_d = cnt_q + 1'b1;
        rx_d  = byte_now[BYTE_W-2:0];
      end
      if (last_bit) begin
        case (cur_ph)
          PH_OPCODE: begin
            if (opc_ok) begin
              phase_d = PH_ADDR;
              rd_d    = byte_now[0];
            end else begin
              phase_d = PH_SKIP;
            end
          end
          PH_ADDR: begin
            phase_d   = PH_DATA;
            addr_load = 1'b1;
          end
          PH_DATA: begin
            step_d = 1'b1;
            wr_d   = ~rd_q;
            if (!rd_q) wb_d = byte_now;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      step_q  <= 1'b0;
      wb_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      step_q  <= step_d;
      wb_q    <= wb_d;
    end
  end

  assign phase      = phase_q;
  assign rd_mode    = rd_q;
  assign bit_cnt    = cnt_q;
  assign addr_val   = byte_now;
  assign wr_pulse   = wr_q;
  assign step_pulse = step_q;
  assign wr_byte    = wb_q;

endmodule

// File: rtl/spi_ptr.sv
module spi_ptr
  import spi_regacc_pkg::*;
#(
  parameter int LAST_REG = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              step,
  input  logic              seq_en,
  output logic [BYTE_W-1:0] ptr
);

  localparam logic [BYTE_W-1:0] LAST = BYTE_W'(LAST_REG);

  logic [BYTE_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load) begin
      ptr_d = load_val;
    end else if (step && seq_en) begin
      ptr_d = (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/spi_tx.sv
module spi_tx
  import spi_regacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              shift,
  output logic              out_bit
);

  logic [BYTE_W-1:0] tx_q, tx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)       tx_d = load_val;
    else if (shift) tx_d = {tx_q[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  assign out_bit = tx_q[BYTE_W-1];

endmodule

// File: rtl/spi_regacc.sv
module spi_regacc
  import spi_regacc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LAST_REG    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic [1:0]        hw_addr,
  input  logic              addr_cmp_en,
  input  logic              seq_en,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [BYTE_W-1:0] reg_rdata
);

  localparam int PIN_W = 3;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [PIN_W-1:0]  pins_s;
  logic              cs_s, sck_s, mosi_s;
  logic              sck_prev_q;
  logic              sck_rise, sck_fall, cs_act;
  phase_t            phase;
  logic              rd_mode;
  logic [CNT_W-1:0]  bit_cnt;
  logic              addr_load;
  logic [BYTE_W-1:0] addr_val;
  logic              wr_pulse, step_pulse;
  logic [BYTE_W-1:0] wr_byte;
  logic              tx_load;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  spi_pin_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({cs_n, sck, mosi}),
    .q     (pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sck_prev_q <= 1'b0;
    else            sck_prev_q <= sck_s;
  end

  assign cs_act   = ~cs_s;
  assign sck_rise = sck_s & ~sck_prev_q;
  assign sck_fall = ~sck_s & sck_prev_q;

  spi_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cs_act      (cs_act),
    .sck_rise    (sck_rise),
    .mosi_s      (mosi_s),
    .hw_addr     (hw_addr),
    .addr_cmp_en (addr_cmp_en),
    .phase       (phase),
    .rd_mode     (rd_mode),
    .bit_cnt     (bit_cnt),
    .addr_load   (addr_load),
    .addr_val    (addr_val),
    .wr_pulse    (wr_pulse),
    .step_pulse  (step_pulse),
    .wr_byte     (wr_byte)
  );

  spi_ptr #(
    .LAST_REG (LAST_REG)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (addr_load),
    .load_val (addr_val),
    .step     (step_pulse),
    .seq_en   (seq_en),
    .ptr      (reg_addr)
  );

  // a read byte is fetched on the falling edge that opens it
  assign tx_load = sck_fall & cs_act & (phase == PH_DATA) & rd_mode &
                   (bit_cnt == '0);

  spi_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tx_load),
    .load_val (reg_rdata),
    .shift    (sck_fall & cs_act),
    .out_bit  (miso)
  );

  assign miso_oe   = (phase == PH_DATA) & rd_mode;
  assign reg_we    = wr_pulse;
  assign reg_wdata = wr_byte;
  assign reg_re    = tx_load;

endmodule

// File: rtl/spi_regacc_chk.sv
module spi_regacc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso_oe,
  input logic       reg_we,
  input logic       reg_re,
  input logic [7:0] reg_addr
);

  logic [2:0] cs_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cs_hi_cnt <= '0;
    else if (!cs_n)          cs_hi_cnt <= '0;
    else if (cs_hi_cnt != 7) cs_hi_cnt <= cs_hi_cnt + 1'b1;
  end

  // R11
  oe_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi_cnt >= 3'd5) |-> !miso_oe);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  // R5
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5
  we_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));

  // R6
  re_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> miso_oe);

  // R4
  we_not_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !miso_oe);

endmodule

bind spi_regacc spi_regacc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .miso_oe  (miso_oe),
  .reg_we   (reg_we),
  .reg_re   (reg_re),
  .reg_addr (reg_addr)
);

// File: tb/spi_regacc_tb.sv
module spi_regacc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int LAST       = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic       miso, miso_oe;
  logic [1:0] hw_addr = 2'b10;
  logic       addr_cmp_en = 1'b1;
  logic       seq_en = 1'b1;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, reg_re;

  logic [7:0]  rf     [0:LAST];
  logic [7:0]  exp_rf [0:LAST];
  logic [15:0] wq [$];
  logic [7:0]  txbuf [4];
  logic [7:0]  rxbuf [4];
  logic        oe_seen [4];
  logic        oe_ok = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regacc u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .hw_addr(hw_addr),
    .addr_cmp_en(addr_cmp_en), .seq_en(seq_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  // behavioural register file behind the port
  assign reg_rdata = (reg_addr <= 8'(LAST)) ? rf[reg_addr[3:0]] : 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= LAST; i++) rf[i] <= 8'hA0 + 8'(i);
    end else if (reg_we && reg_addr <= 8'(LAST)) begin
      rf[reg_addr[3:0]] <= reg_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the expected strobe stream
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we || reg_re) chk("R12 strobes exclusive", {31'd0, reg_we & reg_re}, 32'd0);
      if (reg_we) begin
        if (wq.size() == 0) begin
          chk("R4/R5 unexpected write", {16'd0, reg_addr, reg_wdata}, 32'hFFFF);
        end else begin
          automatic logic [15:0] e = wq.pop_front();
          chk("R5 write addr", {24'd0, reg_addr}, {24'd0, e[15:8]});
          chk("R5 write data", {24'd0, reg_wdata}, {24'd0, e[7:0]});
        end
      end
      if (miso_oe) chk("R4/R11 drive allowed", {31'd0, oe_ok}, 32'd1);
    end
  end

  function automatic logic [7:0] nxt(input logic [7:0] a, input logic s);
    if (!s) return a;
    return (a >= 8'(LAST)) ? 8'h00 : a + 8'h01;
  endfunction

  task automatic spi_byte(input bit m3, input logic [7:0] b,
                          output logic [7:0] r, output logic oe7);
    for (int i = 7; i >= 0; i--) begin
      if (m3) sck = 1'b0;
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      if (i == 7) oe7 = miso_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!m3) sck = 1'b0;
    end
  endtask

  task automatic cs_start(input bit m3);
    sck = m3;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3*HALF) @(negedge clk);
    oe_ok = 1'b0;
  endtask

  task automatic txn(input bit m3, input logic [7:0] op, input logic [7:0] ad, input int n);
    logic [7:0] dr;
    logic       dd;
    cs_start(m3);
    spi_byte(m3, op, dr, dd);
    spi_byte(m3, ad, dr, dd);
    for (int i = 0; i < n; i++) spi_byte(m3, txbuf[i], rxbuf[i], oe_seen[i]);
    cs_end();
  endtask

  task automatic expect_wr(input logic [7:0] start, input int n, input logic s);
    logic [7:0] a = start;
    for (int i = 0; i < n; i++) begin
      wq.push_back({a, txbuf[i]});
      exp_rf[a[3:0]] = txbuf[i];
      a = nxt(a, s);
    end
  endtask

  task automatic check_rd(input string tag, input logic [7:0] start, input int n, input logic s);
    logic [7:0] a = start;
    for (int i = 0; i < n; i++) begin
      chk({tag, " data"}, {24'd0, rxbuf[i]}, {24'd0, exp_rf[a[3:0]]});
      chk({tag, " drive"}, {31'd0, oe_seen[i]}, 32'd1);
      a = nxt(a, s);
    end
  endtask

  task automatic read_txn(input bit m3, input logic [7:0] ad, input int n);
    for (int i = 0; i < 4; i++) txbuf[i] = 8'h00;
    oe_ok = 1'b1;
    txn(m3, 8'h45, ad, n);
  endtask

  initial begin
    for (int i = 0; i <= LAST; i++) exp_rf[i] = 8'hA0 + 8'(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk("R1 miso_oe after reset", {31'd0, miso_oe}, 32'd0);
    chk("R1 reg_we after reset", {31'd0, reg_we}, 32'd0);
    chk("R1 reg_re after reset", {31'd0, reg_re}, 32'd0);

    // R2 R5 mode 0 single write, opcode 0x44 (sub-address 10, write)
    txbuf[0] = 8'h5A;
    expect_wr(8'h03, 1, 1'b1);
    txn(1'b0, 8'h44, 8'h03, 1);
    chk("R5 single write consumed", wq.size(), 0);

    // R7 burst from 0x09 wraps to 0x00
    txbuf[0] = 8'h11; txbuf[1] = 8'h22; txbuf[2] = 8'h33;
    expect_wr(8'h09, 3, 1'b1);
    txn(1'b0, 8'h44, 8'h09, 3);
    chk("R7 wrap burst consumed", wq.size(), 0);

    // R6 R7 R9 mode 1,1 read burst across the wrap
    read_txn(1'b1, 8'h09, 4);
    check_rd("R6 R7 R9 mode3 read", 8'h09, 4, 1'b1);

    // R6 R9 mode 0 read
    read_txn(1'b0, 8'h03, 2);
    check_rd("R6 R9 mode0 read", 8'h03, 2, 1'b1);

    // R8 R9 pointer held, mode 1,1 write
    seq_en = 1'b0;
    txbuf[0] = 8'h55; txbuf[1] = 8'h66; txbuf[2] = 8'h77;
    expect_wr(8'h05, 3, 1'b0);
    txn(1'b1, 8'h44, 8'h05, 3);
    chk("R8 held-pointer writes consumed", wq.size(), 0);
    chk("R8 last value kept", {24'd0, exp_rf[5]}, 32'h77);
    read_txn(1'b0, 8'h06, 3);
    check_rd("R8 held-pointer read", 8'h06, 3, 1'b0);
    seq_en = 1'b1;

    // R2 R4 wrong sub-address, write then read
    txbuf[0] = 8'hE1; txbuf[1] = 8'hE2;
    txn(1'b0, 8'h42, 8'h02, 2);
    txn(1'b0, 8'h43, 8'h02, 2);
    chk("R4 no drive on rejected read", {31'd0, oe_seen[0]}, 32'd0);
    // R4 wrong fixed bits
    txbuf[0] = 8'hE3;
    txn(1'b1, 8'h54, 8'h02, 1);
    read_txn(1'b0, 8'h02, 1);
    check_rd("R4 register untouched", 8'h02, 1, 1'b1);

    // R3 compare off: sub-address must be 00
    addr_cmp_en = 1'b0;
    txbuf[0] = 8'hE4;
    txn(1'b0, 8'h44, 8'h04, 1);
    txbuf[0] = 8'hC4;
    expect_wr(8'h04, 1, 1'b1);
    txn(1'b0, 8'h40, 8'h04, 1);
    chk("R3 opcode 0x40 accepted", wq.size(), 0);
    addr_cmp_en = 1'b1;
    read_txn(1'b1, 8'h04, 1);
    check_rd("R3 readback", 8'h04, 1, 1'b1);

    // R10 chip select raised mid-byte
    begin
      logic [7:0] dr;
      logic       dd;
      txbuf[0] = 8'h99;
      expect_wr(8'h07, 1, 1'b1);
      cs_start(1'b0);
      spi_byte(1'b0, 8'h44, dr, dd);
      spi_byte(1'b0, 8'h07, dr, dd);
      spi_byte(1'b0, txbuf[0], dr, dd);
      for (int i = 0; i < 4; i++) begin
        mosi = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
      end
      cs_end();
    end
    chk("R10 only complete byte written", wq.size(), 0);
    read_txn(1'b0, 8'h07, 2);
    check_rd("R10 readback", 8'h07, 2, 1'b1);

    // R11 drive released after a read ends
    chk("R11 miso_oe low after cs_n high", {31'd0, miso_oe}, 32'd0);

    repeat (10) @(negedge clk);
    chk("R5 no pending writes", wq.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule